// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block gives the column address for each beat of an SDRAM burst. A load pulse captures the starting column, the burst length code and the ordering choice. From then on the block presents one column per clock while the advance input is high. It also flags the final beat of a fixed-length burst.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block of that size. Within that block the ordering is either sequential (an add that wraps) or interleaved (an XOR with the beat index). A full-page burst walks the whole row and wraps at the row end. It runs until it is stopped. A terminate input ends any burst at once. A new load on any clock drops the current burst and starts the new one.

Top module: `sdram_col_gen`

## Requirements
- R1: After reset, beat_valid and last_beat are low until the first load.
- R2: bl_sel encodes the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and values 4 to 7 give a full-page burst. A fixed burst produces exactly that many beats and then no more, even with advance held high.
- R3: In sequential order, beat k has column bits above log2(BL) equal to the start, and low log2(BL) bits equal to (start + k) mod BL.
- R4: In interleaved order (interleave = 1), beat k has the low log2(BL) bits equal to start XOR k, and the upper bits equal to the start.
- R5: In full-page mode, beat k has column (start + k) mod 2^COL_W (256 columns by default), and the burst does not end by itself.
- R6: Full-page mode ignores interleave and always uses sequential order.
- R7: last_beat is high together with beat_valid on beat BL-1 of a fixed burst, and is never high in full-page mode.
- R8: load takes priority on any clock. The next cycle presents beat 0 at the new start column, and the old burst produces no more beats.
- R9: A cycle with terminate high (and load low) produces no beat. No beats follow it until the next load.
- R10: A beat is produced in a cycle only when the burst is active, advance is high, and load and terminate are low. With advance low, col holds and the beat is not consumed.
- R11: A burst of length 1 produces one beat at the start column, with last_beat high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture the start settings and begin a burst |
| start_col | input | COL_W | Starting column |
| bl_sel | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects interleaved order |
| advance | input | 1 | Consume the current beat this clock |
| terminate | input | 1 | End the burst now |
| col | output | COL_W | Column for the current beat |
| beat_valid | output | 1 | A beat is presented and consumed this clock |
| last_beat | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The bench uses start columns whose low bits are not zero. With such starts, a generator that fails to keep the upper bits, or that carries out of the aligned block, gives a wrong column within the first few beats. It also uses starts where interleaved and sequential orders differ, so a swapped or missing XOR shows up.

A full-page run crosses the row end, which catches a counter that stops or saturates instead of wrapping. The bench then terminates the burst and holds advance high, so any stray beat after the stop is reported. The same check follows every fixed burst, which catches a burst that runs past its length. A reload partway through a burst, and a stall with advance low, catch a design that keeps the old sequence or skips a column.

// File: rtl/sdram_col_gen.sv
module sdram_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_sel,
  input  logic             interleave,
  input  logic             advance,
  input  logic             terminate,
  output logic [COL_W-1:0] col,
  output logic             beat_valid,
  output logic             last_beat
);

  logic             active, fp_q, il_q;
  logic [COL_W-1:0] base, cnt, mask_q, new_mask, low;
  logic             at_end;

  assign new_mask   = bl_sel[2] ? {COL_W{1'b1}} : ~({COL_W{1'b1}} << bl_sel[1:0]);
  assign low        = il_q ? (base ^ cnt) : (base + cnt);
  assign col        = (base & ~mask_q) | (low & mask_q);
  assign at_end     = !fp_q && (cnt == mask_q);
  assign beat_valid = active && advance && !load && !terminate;
  assign last_beat  = beat_valid && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      fp_q   <= 1'b0;
      il_q   <= 1'b0;
      base   <= '0;
      cnt    <= '0;
      mask_q <= '0;
    end else if (load) begin
      active <= 1'b1;
      base   <= start_col;
      cnt    <= '0;
      fp_q   <= bl_sel[2];
      il_q   <= interleave && !bl_sel[2];
      mask_q <= new_mask;
    end else if (terminate) begin
      active <= 1'b0;
    end else if (beat_valid) begin
      if (at_end) active <= 1'b0;
      else        cnt    <= cnt + 1'b1;
    end
  end

  assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> beat_valid);

  assert_end_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> !beat_valid);

  assert_term_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (terminate && !load) |=> !beat_valid);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !advance && !load && !terminate) |=> $stable(col));

  assert_load_col_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (col == $past(start_col)));

endmodule

// File: tb/tb_sdram_col_gen.sv
module tb_sdram_col_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0, interleave = 1'b0, advance = 1'b0, terminate = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] bl_sel = '0;
  logic [7:0] col;
  logic       beat_valid, last_beat;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [8:0] exp_q[$];
  string      req_q[$];

  sdram_col_gen #(.COL_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .start_col(start_col), .bl_sel(bl_sel),
    .interleave(interleave), .advance(advance), .terminate(terminate),
    .col(col), .beat_valid(beat_valid), .last_beat(last_beat));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [2:0] sel,
                                         input logic il, input int k);
    logic [7:0] m, lo;
    m  = sel[2] ? 8'hFF : 8'((1 << sel[1:0]) - 1);
    lo = (il && !sel[2]) ? (s ^ 8'(k)) : (s + 8'(k));
    return (s & ~m) | (lo & m);
  endfunction

  always @(negedge clk) begin
    if (rst_n && beat_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2/R9 unexpected beat", int'(col), -1);
      end else begin
        logic [8:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk({last_beat, col} == e, r, int'({last_beat, col}), int'(e));
      end
    end
  end

  task automatic go(input logic [7:0] s, input logic [2:0] sel, input logic il,
                    input int n, input string req);
    int bl;
    bl = sel[2] ? 0 : (1 << sel[1:0]);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back({(bl != 0 && k == bl - 1), exp_col(s, sel, il, k)});
      req_q.push_back(req);
    end
    @(posedge clk); #1;
    load = 1; start_col = s; bl_sel = sel; interleave = il; advance = 1;
    @(posedge clk); #1;
    load = 0;
    repeat (n) @(posedge clk);
    #1 advance = 0;
    chk(exp_q.size() == 0, {req, " beat count"}, exp_q.size(), 0);
  endtask

  task automatic idle(input int n, input string req);
    advance = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(beat_valid == 0 && last_beat == 0, req, int'(beat_valid), 0);
    end
    @(posedge clk); #1 advance = 0;
  endtask

  task automatic stop_burst();
    @(posedge clk); #1 terminate = 1; advance = 1;
    @(negedge clk);
    chk(beat_valid == 0, "R9 no beat with terminate", int'(beat_valid), 0);
    @(posedge clk); #1 terminate = 0; advance = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(beat_valid == 0 && last_beat == 0, "R1 reset outputs", int'({beat_valid, last_beat}), 0);
    #1 rst_n = 1;
    advance = 1;
    @(negedge clk);
    chk(beat_valid == 0, "R1 idle before load", int'(beat_valid), 0);
    advance = 0;

    go(8'h35, 3'd2, 0, 4, "R3/R7 seq BL4");       idle(3, "R2 BL4 ends");
    go(8'h1D, 3'd3, 0, 8, "R3/R7 seq BL8");       idle(3, "R2 BL8 ends");
    go(8'h1D, 3'd3, 1, 8, "R4/R7 il BL8");        idle(2, "R2 il BL8 ends");
    go(8'h36, 3'd2, 1, 4, "R4 il BL4");           idle(2, "R2 il BL4 ends");
    go(8'h0F, 3'd1, 0, 2, "R3 seq BL2");          idle(2, "R2 BL2 ends");
    go(8'h0F, 3'd1, 1, 2, "R4 il BL2");           idle(2, "R2 il BL2 ends");
    go(8'h77, 3'd0, 0, 1, "R11 BL1");             idle(2, "R11 BL1 single beat");

    go(8'hF0, 3'd7, 0, 300, "R5/R7 full page wrap");
    stop_burst();                                  idle(4, "R9 nothing after terminate");
    go(8'hFE, 3'd4, 1, 20, "R6 full page ignores interleave");
    stop_burst();                                  idle(2, "R9 nothing after terminate fp");

    go(8'h40, 3'd3, 0, 3, "R8 first burst part");
    go(8'h13, 3'd2, 1, 4, "R8 reload restarts");  idle(3, "R8 old burst gone");

    go(8'h5B, 3'd3, 1, 4, "R9 partial BL8");
    stop_burst();                                  idle(3, "R9 early stop");

    for (int k = 0; k < 4; k++) begin
      exp_q.push_back({k == 3, exp_col(8'h2A, 3'd2, 0, k)});
      req_q.push_back("R10 stall burst");
    end
    @(posedge clk); #1 load = 1; start_col = 8'h2A; bl_sel = 3'd2; interleave = 0; advance = 1;
    @(posedge clk); #1 load = 0;
    repeat (2) @(posedge clk);
    #1 advance = 0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(beat_valid == 0 && col == exp_col(8'h2A, 3'd2, 0, 2), "R10 stall holds col",
          int'(col), int'(exp_col(8'h2A, 3'd2, 0, 2)));
    end
    @(posedge clk); #1 advance = 1;
    repeat (2) @(posedge clk);
    #1 advance = 0;
    chk(exp_q.size() == 0, "R10 beats after stall", exp_q.size(), 0);
    idle(2, "R2 stalled burst ends");

    summary();
  end
endmodule